// File: doc/BRIEF.md
# Two-Level Write-Back Cache Tag Controller

This block keeps the tag and state side of a two-level cache hierarchy. The upper level is direct-mapped. It is backed by a 2-way set-associative lower level, which is in turn backed by main memory. The block takes one CPU request at a time, either a read or a write to a byte address. It looks the request up in both levels and keeps the valid, dirty and least-recently-used bits up to date. It issues whole-block read and write transactions on a memory port. Data bytes are not stored. Only tags, state bits and the order of traffic between the levels are modelled.

Both levels are write-back and write-allocate. Whenever a miss displaces a dirty line, that line is pushed to the level below before the missing block is requested. A dirty line leaving the upper level arrives at the lower level as an ordinary write. That write counts as a lower-level access and refreshes its recency. The block keeps a set of event counters, one per level and event kind, and a total of memory transactions. Software-visible use is by reading the counter outputs after each request completes.

Top module: `twolevel_cache_ctrl`

## Requirements
- R1: After reset every line in both levels is invalid, every counter output reads zero, `req_ready` is high, and `req_done` and `mem_valid` are low.
- R2: The upper level has 16 sets of 16-byte blocks. Address bits [7:4] select the set and bits [31:8] form the tag. Bits [3:0] do not affect hit or miss. Two blocks with equal bits [7:4] and different tags evict each other, and blocks with different bits [7:4] coexist.
- R3: The lower level has 256 sets of 2 ways with 16-byte blocks. Address bits [11:4] select the set and bits [31:12] form the tag. Two blocks with different tags in one set are held at the same time.
- R4: A write miss first fetches the block, seen as a read transaction when the lower level also misses, and then marks the upper-level line dirty. A later write hit to that line causes no memory transaction.
- R5: A block filled from below is installed clean, so evicting it after reads only causes no writeback and no lower-level write.
- R6: A dirty upper-level victim is sent to the lower level as a write before the new block is requested. It counts as a lower-level write, and a hit there marks that lower-level line dirty without any memory transaction.
- R7: When a lower-level miss evicts a dirty line, a memory write of that line's block address (`mem_write`=1) completes before the memory read of the missing block (`mem_write`=0). A clean victim causes no memory write.
- R8: A lower-level fill uses an invalid way first, way 0 when both are invalid. With both ways valid, it replaces the way least recently hit or filled.
- R9: The counters report upper-level reads, read misses, writes, write misses and writebacks, and the same five events for the lower level. `mem_traffic` counts memory transactions, and at every completion it equals lower-level read misses plus write misses plus writebacks.
- R10: `mem_addr` is the 28-bit block address (byte address bits [31:4]). Once `mem_valid` is raised, it stays high with `mem_addr` and `mem_write` unchanged until a cycle with `mem_ready` high. Only one transaction is in flight at a time.
- R11: `req_ready` is high only while idle, and a request is taken on a cycle with `req_valid` and `req_ready`. `req_done` is a one-cycle pulse after all writebacks and fills caused by the request. An upper-level hit raises `req_done` two cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | CPU byte address |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory transaction request |
| mem_write | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 28 | Block address |
| mem_ready | input | 1 | Memory accepts and completes the transaction |
| l1_reads | output | 32 | Upper-level read requests |
| l1_read_misses | output | 32 | Upper-level read misses |
| l1_writes | output | 32 | Upper-level write requests |
| l1_write_misses | output | 32 | Upper-level write misses |
| l1_writebacks | output | 32 | Dirty upper-level victims sent below |
| l2_reads | output | 32 | Lower-level read requests |
| l2_read_misses | output | 32 | Lower-level read misses |
| l2_writes | output | 32 | Lower-level write requests |
| l2_write_misses | output | 32 | Lower-level write misses |
| l2_writebacks | output | 32 | Dirty lower-level victims written to memory |
| mem_traffic | output | 32 | Total memory transactions |

## Verification
A four-request trace of write-miss, dirty-victim read, double-eviction read and write-hit is replayed against a hand-computed sequence of memory transactions and final counter values. This separates a write-allocate dirty line from a clean fill, and a lower-level write hit from a memory writeback. A pattern of three tags in one lower-level set, accessed in an order where plain FIFO and LRU pick different victims, shows which way is replaced. A pattern of blocks in distinct and colliding upper-level sets shows the split of index and tag. A chain of dirty writes with back-to-back memory transactions checks that the writeback always precedes the fetch, while the memory latency is varied.

// File: rtl/cache2_pkg.sv
package cache2_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_L1,
      S_L2,
      S_MWB,
      S_MRD,
      S_NEXT,
      S_DONE
   } cc_state_t;

   // event counter slots
   localparam int C_L1_RD  = 0;
   localparam int C_L1_RM  = 1;
   localparam int C_L1_WR  = 2;
   localparam int C_L1_WM  = 3;
   localparam int C_L1_WB  = 4;
   localparam int C_L2_RD  = 5;
   localparam int C_L2_RM  = 6;
   localparam int C_L2_WR  = 7;
   localparam int C_L2_WM  = 8;
   localparam int C_L2_WB  = 9;
   localparam int C_MEM    = 10;
   localparam int NUM_CNT  = 11;

endpackage

// File: rtl/event_counter.sv
module event_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + 1'b1;
   end
endmodule

// File: rtl/dm_tag_store.sv
module dm_tag_store #(
   parameter int SETS  = 16,
   parameter int TAG_W = 24,
   localparam int IW   = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    idx,
   output logic             line_v,
   output logic             line_d,
   output logic [TAG_W-1:0] line_tag,
   input  logic             wr_en,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_dirty
);
   logic [SETS-1:0]  val_q, dty_q;
   logic [TAG_W-1:0] tag_q [SETS];

   generate
      if ((1 << IW) != SETS) begin : g_bad_sets
         $error("dm_tag_store: SETS must be a power of two");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         dty_q <= '0;
      end else if (wr_en) begin
         val_q[idx] <= 1'b1;
         dty_q[idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[idx] <= wr_tag;
   end

   assign line_v   = val_q[idx];
   assign line_d   = dty_q[idx];
   assign line_tag = tag_q[idx];
endmodule

// File: rtl/sa2_tag_store.sv
module sa2_tag_store #(
   parameter int SETS  = 256,
   parameter int TAG_W = 20,
   localparam int IW   = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   output logic             hit_way,
   output logic             hit_dirty,
   output logic             vic_way,
   output logic             vic_valid,
   output logic             vic_dirty,
   output logic [TAG_W-1:0] vic_tag,
   input  logic             wr_en,
   input  logic             wr_way,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_dirty
);
   logic [1:0]       way_hit, way_v, way_d;
   logic [TAG_W-1:0] way_t [2];
   logic [SETS-1:0]  lru_q;   // holds the way to replace next

   generate
      if ((1 << IW) != SETS) begin : g_bad_sets
         $error("sa2_tag_store: SETS must be a power of two");
      end
      for (genvar w = 0; w < 2; w++) begin : g_way
         logic [SETS-1:0]  val_q, dty_q;
         logic [TAG_W-1:0] tag_q [SETS];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               val_q <= '0;
               dty_q <= '0;
            end else if (wr_en && wr_way == w[0]) begin
               val_q[idx] <= 1'b1;
               dty_q[idx] <= wr_dirty;
            end
         end

         always_ff @(posedge clk) begin
            if (wr_en && wr_way == w[0]) tag_q[idx] <= wr_tag;
         end

         assign way_v[w]   = val_q[idx];
         assign way_d[w]   = dty_q[idx];
         assign way_t[w]   = tag_q[idx];
         assign way_hit[w] = val_q[idx] && (tag_q[idx] == lk_tag);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     lru_q <= '0;
      else if (wr_en) lru_q[idx] <= ~wr_way;
   end

   assign hit       = |way_hit;
   assign hit_way   = way_hit[1];
   assign hit_dirty = way_d[hit_way];
   assign vic_way   = !way_v[0] ? 1'b0 : (!way_v[1] ? 1'b1 : lru_q[idx]);
   assign vic_valid = way_v[vic_way];
   assign vic_dirty = way_d[vic_way];
   assign vic_tag   = way_t[vic_way];

   // a block lives in at most one way of its set
   p_unique_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(way_hit) <= 1);

   // a fill never displaces a valid line while the other way is empty (R8)
   p_invalid_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !way_hit[wr_way] && way_v[wr_way]) |-> way_v[~wr_way]);
endmodule

// File: rtl/twolevel_cache_ctrl.sv
module twolevel_cache_ctrl
   import cache2_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BLK_BYTES = 16,
   parameter int L1_SETS   = 16,
   parameter int L2_SETS   = 256,
   parameter int CNT_W     = 32,
   localparam int OFF_W    = $clog2(BLK_BYTES),
   localparam int BA_W     = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              req_done,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [BA_W-1:0]   mem_addr,
   input  logic              mem_ready,
   output logic [CNT_W-1:0]  l1_reads,
   output logic [CNT_W-1:0]  l1_read_misses,
   output logic [CNT_W-1:0]  l1_writes,
   output logic [CNT_W-1:0]  l1_write_misses,
   output logic [CNT_W-1:0]  l1_writebacks,
   output logic [CNT_W-1:0]  l2_reads,
   output logic [CNT_W-1:0]  l2_read_misses,
   output logic [CNT_W-1:0]  l2_writes,
   output logic [CNT_W-1:0]  l2_write_misses,
   output logic [CNT_W-1:0]  l2_writebacks,
   output logic [CNT_W-1:0]  mem_traffic
);
   localparam int L1_IW = $clog2(L1_SETS);
   localparam int L1_TW = BA_W - L1_IW;
   localparam int L2_IW = $clog2(L2_SETS);
   localparam int L2_TW = BA_W - L2_IW;

   generate
      if ((1 << OFF_W) != BLK_BYTES) begin : g_bad_blk
         $error("twolevel_cache_ctrl: BLK_BYTES must be a power of two");
      end
      if (L1_IW >= BA_W || L2_IW >= BA_W) begin : g_bad_idx
         $error("twolevel_cache_ctrl: index wider than block address");
      end
   endgenerate

   cc_state_t         st, nxt;
   logic [BA_W-1:0]   cur_addr, l2_addr, wb_addr;
   logic              cur_write, l2_is_wb, vway_q;
   logic [NUM_CNT-1:0] inc;

   // upper level
   logic [L1_IW-1:0]  l1_idx;
   logic [L1_TW-1:0]  l1_ctag, l1_tag;
   logic              l1_v, l1_d, l1_hit, l1_we, l1_wd;
   assign l1_idx  = cur_addr[L1_IW-1:0];
   assign l1_ctag = cur_addr[BA_W-1:L1_IW];
   assign l1_hit  = l1_v && (l1_tag == l1_ctag);

   dm_tag_store #(.SETS(L1_SETS), .TAG_W(L1_TW)) u_l1 (
      .clk, .rst_n, .idx(l1_idx),
      .line_v(l1_v), .line_d(l1_d), .line_tag(l1_tag),
      .wr_en(l1_we), .wr_tag(l1_ctag), .wr_dirty(l1_wd)
   );

   // lower level
   logic [L2_IW-1:0]  l2_idx;
   logic [L2_TW-1:0]  l2_ctag, vic_tag;
   logic              l2_hit, hit_way, hit_d, vic_way, vic_v, vic_d;
   logic              l2_we, l2_ww, l2_wd;
   assign l2_idx  = l2_addr[L2_IW-1:0];
   assign l2_ctag = l2_addr[BA_W-1:L2_IW];

   sa2_tag_store #(.SETS(L2_SETS), .TAG_W(L2_TW)) u_l2 (
      .clk, .rst_n, .idx(l2_idx), .lk_tag(l2_ctag),
      .hit(l2_hit), .hit_way(hit_way), .hit_dirty(hit_d),
      .vic_way(vic_way), .vic_valid(vic_v), .vic_dirty(vic_d), .vic_tag(vic_tag),
      .wr_en(l2_we), .wr_way(l2_ww), .wr_tag(l2_ctag), .wr_dirty(l2_wd)
   );

   always_comb begin
      nxt       = st;
      inc       = '0;
      l1_we     = 1'b0;
      l1_wd     = 1'b0;
      l2_we     = 1'b0;
      l2_ww     = hit_way;
      l2_wd     = 1'b0;
      mem_valid = 1'b0;
      mem_write = 1'b0;
      mem_addr  = l2_addr;
      case (st)
         S_IDLE: if (req_valid) begin
            inc[req_write ? C_L1_WR : C_L1_RD] = 1'b1;
            nxt = S_L1;
         end
         S_L1: if (l1_hit) begin
            l1_we = cur_write;
            l1_wd = 1'b1;
            nxt   = S_DONE;
         end else begin
            inc[cur_write ? C_L1_WM : C_L1_RM] = 1'b1;
            inc[C_L1_WB] = l1_v && l1_d;
            nxt = S_L2;
         end
         S_L2: begin
            inc[l2_is_wb ? C_L2_WR : C_L2_RD] = 1'b1;
            if (l2_hit) begin
               l2_we = 1'b1;
               l2_wd = hit_d | l2_is_wb;
               nxt   = S_NEXT;
            end else begin
               inc[l2_is_wb ? C_L2_WM : C_L2_RM] = 1'b1;
               inc[C_L2_WB] = vic_v && vic_d;
               nxt = (vic_v && vic_d) ? S_MWB : S_MRD;
            end
         end
         S_MWB: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_addr  = wb_addr;
            if (mem_ready) nxt = S_MRD;
         end
         S_MRD: begin
            mem_valid = 1'b1;
            if (mem_ready) begin
               l2_we = 1'b1;
               l2_ww = vway_q;
               l2_wd = l2_is_wb;
               nxt   = S_NEXT;
            end
         end
         S_NEXT: if (l2_is_wb) begin
            nxt = S_L2;
         end else begin
            l1_we = 1'b1;
            l1_wd = cur_write;
            nxt   = S_DONE;
         end
         default: nxt = S_IDLE;
      endcase
      inc[C_MEM] = mem_valid && mem_ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         cur_addr  <= '0;
         cur_write <= 1'b0;
         l2_addr   <= '0;
         l2_is_wb  <= 1'b0;
         wb_addr   <= '0;
         vway_q    <= 1'b0;
      end else begin
         st <= nxt;
         case (st)
            S_IDLE: if (req_valid) begin
               cur_addr  <= req_addr[ADDR_W-1:OFF_W];
               cur_write <= req_write;
            end
            S_L1: if (!l1_hit) begin
               l2_is_wb <= l1_v && l1_d;
               l2_addr  <= (l1_v && l1_d) ? {l1_tag, l1_idx} : cur_addr;
            end
            S_L2: if (!l2_hit) begin
               vway_q  <= vic_way;
               wb_addr <= {vic_tag, l2_idx};
            end
            S_NEXT: if (l2_is_wb) begin
               l2_is_wb <= 1'b0;
               l2_addr  <= cur_addr;
            end
            default: ;
         endcase
      end
   end

   assign req_ready = (st == S_IDLE);
   assign req_done  = (st == S_DONE);

   logic [CNT_W-1:0] cnt [NUM_CNT];
   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
         event_counter #(.W(CNT_W)) u_cnt (
            .clk, .rst_n, .inc(inc[i]), .count(cnt[i])
         );
      end
   endgenerate

   assign l1_reads        = cnt[C_L1_RD];
   assign l1_read_misses  = cnt[C_L1_RM];
   assign l1_writes       = cnt[C_L1_WR];
   assign l1_write_misses = cnt[C_L1_WM];
   assign l1_writebacks   = cnt[C_L1_WB];
   assign l2_reads        = cnt[C_L2_RD];
   assign l2_read_misses  = cnt[C_L2_RM];
   assign l2_writes       = cnt[C_L2_WR];
   assign l2_write_misses = cnt[C_L2_WM];
   assign l2_writebacks   = cnt[C_L2_WB];
   assign mem_traffic     = cnt[C_MEM];

   logic unused_offset;
   assign unused_offset = ^req_addr[OFF_W-1:0];

   p_traffic_sum_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> mem_traffic == l2_read_misses + l2_write_misses + l2_writebacks);

   p_wb_as_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> l2_writes == l1_writebacks);

   p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> (!req_done && req_ready));

   p_miss_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_read_misses <= l1_reads) && (l2_write_misses <= l2_writes));
endmodule

// File: tb/twolevel_cache_ctrl_bench.sv
module twolevel_cache_ctrl_bench;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready, req_done;
   logic        mem_valid, mem_write, mem_ready = 1'b0;
   logic [27:0] mem_addr;
   logic [31:0] c_l1rd, c_l1rm, c_l1wr, c_l1wm, c_l1wb;
   logic [31:0] c_l2rd, c_l2rm, c_l2wr, c_l2wm, c_l2wb, c_mem;

   int n_tests = 0, n_fail = 0;
   int mem_lat = 1;
   int n_ops = 0;
   logic        op_w [16];
   logic [27:0] op_a [16];
   int last_cycles = 0;

   always #(PERIOD/2) clk = ~clk;

   twolevel_cache_ctrl u_twolevel_cache_ctrl (
      .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_ready, .req_done,
      .mem_valid, .mem_write, .mem_addr, .mem_ready,
      .l1_reads(c_l1rd), .l1_read_misses(c_l1rm), .l1_writes(c_l1wr),
      .l1_write_misses(c_l1wm), .l1_writebacks(c_l1wb),
      .l2_reads(c_l2rd), .l2_read_misses(c_l2rm), .l2_writes(c_l2wr),
      .l2_write_misses(c_l2wm), .l2_writebacks(c_l2wb), .mem_traffic(c_mem)
   );

   // memory model: answers after mem_lat waiting cycles, logs each transaction
   initial begin
      int waitc = 0;
      forever begin
         @(negedge clk);
         if (mem_ready) begin
            mem_ready = 1'b0;
         end else if (mem_valid) begin
            if (waitc >= mem_lat) begin
               mem_ready = 1'b1;
               if (n_ops < 16) begin
                  op_w[n_ops] = mem_write;
                  op_a[n_ops] = mem_addr;
               end
               n_ops++;
               waitc = 0;
            end else begin
               waitc++;
            end
         end
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_cnt(input string tag, input int unsigned e [11]);
      logic [31:0] a [11];
      a = '{c_l1rd, c_l1rm, c_l1wr, c_l1wm, c_l1wb,
            c_l2rd, c_l2rm, c_l2wr, c_l2wm, c_l2wb, c_mem};
      for (int i = 0; i < 11; i++) begin
         check($sformatf("%s counter%0d", tag, i), 64'(a[i]), 64'(e[i]));
      end
   endtask

   // one CPU request; fills the op log and checks ready/done behaviour (R11)
   task automatic do_req(input logic wr, input logic [31:0] addr);
      int cyc = 0;
      bit busy_bad = 0;
      n_ops = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = addr;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!req_done && cyc < 300) begin
         if (req_ready) busy_bad = 1;
         @(negedge clk);
         cyc++;
      end
      last_cycles = cyc;
      if (cyc >= 300) begin
         n_tests++;
         n_fail++;
         $display("FAIL R11 request timeout actual=%0d expected=<300", cyc);
      end
      check("R11 req_ready low while busy", 64'(busy_bad), 64'd0);
      @(negedge clk);
      check("R11 done is a single pulse", 64'(req_done), 64'd0);
      check("R11 ready after done", 64'(req_ready), 64'd1);
   endtask

   task automatic chk_op(input string tag, input int i, input logic w, input logic [27:0] a);
      check({tag, " op kind"}, 64'(op_w[i]), 64'(w));
      check({tag, " op addr"}, 64'(op_a[i]), 64'(a));
   endtask

   task automatic t_reset;
      check("R1 req_ready", 64'(req_ready), 64'd1);
      check("R1 req_done", 64'(req_done), 64'd0);
      check("R1 mem_valid", 64'(mem_valid), 64'd0);
      chk_cnt("R1", '{0,0,0,0,0,0,0,0,0,0,0});
   endtask

   task automatic t_trace;
      mem_lat = 1;
      do_req(1'b1, 32'h10001AC4);
      check("R4 write miss ops", 64'(n_ops), 64'd1);
      chk_op("R4 allocate read", 0, 1'b0, 28'h10001AC);
      do_req(1'b0, 32'h10002AC2);
      check("R6 dirty victim absorbed by L2", 64'(n_ops), 64'd1);
      chk_op("R6 fetch", 0, 1'b0, 28'h10002AC);
      check("R6 l2 writes", 64'(c_l2wr), 64'd1);
      check("R6 l2 write misses", 64'(c_l2wm), 64'd0);
      do_req(1'b0, 32'h10003AC6);
      check("R7 writeback then read", 64'(n_ops), 64'd2);
      chk_op("R7 first is writeback", 0, 1'b1, 28'h10001AC);
      chk_op("R7 second is fetch", 1, 1'b0, 28'h10003AC);
      check("R5 clean victim no l1 writeback", 64'(c_l1wb), 64'd1);
      do_req(1'b1, 32'h10003AC7);
      check("R4 write hit no traffic", 64'(n_ops), 64'd0);
      check("R11 hit latency", 64'(last_cycles), 64'd2);
      chk_cnt("R9 trace", '{2,2,2,1,1,3,3,1,0,1,4});
   endtask

   task automatic t_index;
      mem_lat = 0;
      do_req(1'b0, 32'h00000010);
      do_req(1'b0, 32'h00000020);
      check("R2 distinct sets fetched", 64'(c_mem), 64'd6);
      do_req(1'b0, 32'h00000018);
      check("R2 offset ignored, hit", 64'(n_ops), 64'd0);
      check("R2 l1 read misses", 64'(c_l1rm), 64'd4);
      do_req(1'b0, 32'h00000110);
      check("R3 different l2 set fetch", 64'(n_ops), 64'd1);
      chk_op("R3 fetch addr", 0, 1'b0, 28'h0000011);
      do_req(1'b0, 32'h00000010);
      check("R2 l1 conflict miss", 64'(c_l1rm), 64'd6);
      check("R3 l2 still holds block", 64'(n_ops), 64'd0);
   endtask

   task automatic t_lru;
      mem_lat = 3;
      do_req(1'b0, 32'h00010500);
      chk_op("R8 fill A", 0, 1'b0, 28'h0001050);
      do_req(1'b0, 32'h00020500);
      chk_op("R8 fill B", 0, 1'b0, 28'h0002050);
      do_req(1'b0, 32'h00010500);
      check("R8 A kept in other way", 64'(n_ops), 64'd0);
      do_req(1'b0, 32'h00030500);
      check("R8 clean victim single op", 64'(n_ops), 64'd1);
      chk_op("R8 fill C", 0, 1'b0, 28'h0003050);
      do_req(1'b0, 32'h00010500);
      check("R8 LRU spared recently used A", 64'(n_ops), 64'd0);
      do_req(1'b0, 32'h00020500);
      check("R8 B was replaced", 64'(n_ops), 64'd1);
   endtask

   task automatic t_dirty_chain;
      mem_lat = 0;
      do_req(1'b1, 32'h00040700);
      do_req(1'b1, 32'h00050700);
      check("R6 dirty victim hits in L2", 64'(n_ops), 64'd1);
      chk_op("R6 fetch Y", 0, 1'b0, 28'h0005070);
      do_req(1'b0, 32'h00060700);
      check("R7 chain ops", 64'(n_ops), 64'd2);
      chk_op("R7 wb X", 0, 1'b1, 28'h0004070);
      chk_op("R7 fetch Z", 1, 1'b0, 28'h0006070);
      do_req(1'b0, 32'h00040700);
      check("R7 second chain ops", 64'(n_ops), 64'd2);
      chk_op("R7 wb Y", 0, 1'b1, 28'h0005070);
      chk_op("R10 fetch X", 1, 1'b0, 28'h0004070);
      check("R9 traffic sum", 64'(c_mem), 64'(c_l2rm + c_l2wm + c_l2wb));
   endtask

   initial begin
      #(PERIOD * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_trace();
      t_index();
      t_lru();
      t_dirty_chain();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule